// File: doc/BRIEF.md
# Parallel SAR ADC Sequencing Controller

This block sits on the host side of a 12-bit successive-approximation converter that has a parallel result bus. It turns a conversion request, or the tick of a programmable internal rate timer, into a convert-start strobe. The falling edge of that strobe is the sampling instant. The block then waits for the converter's busy signal to fall and runs an active-low chip-select and read cycle to capture the 12-bit word. The word is presented as a one-cycle valid/data pair. The converter has no pipeline latency, so each captured word belongs to the sample taken at the convert-start edge just before it.

A spacing guard prevents convert-start edges from coming closer together than the selected speed grade allows. The grades are 400 kSPS, 1 MSPS and 1.25 MSPS. For low-throughput use, an auto-sleep policy can be enabled: the converter dozes between conversions, and the controller inserts a programmable wake delay before each sampling edge. A configuration bit is passed to the converter's partial/full sleep select pin. Requests that arrive at the wrong time are dropped and recorded in a sticky overrun flag. A busy signal that never falls is caught by a watchdog, which sets a sticky timeout flag.

The sequencer is a five-state machine:
- IDLE waits for a trigger.
- WAKE applies the wake delay.
- SAMPLE holds convert-start low.
- CONVERT waits for busy to fall.
- READ drives chip-select and read low.

Its transitions are:
- start: IDLE to WAKE when auto-sleep is on, otherwise IDLE to SAMPLE.
- woken: WAKE to SAMPLE.
- released: SAMPLE to CONVERT.
- done: CONVERT to READ on a busy falling edge.
- expired: CONVERT to IDLE on watchdog expiry.
- captured: READ to IDLE.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, adc_convst_n, adc_cs_n and adc_rd_n are 1, and res_valid, overrun and timeout are 0.
- R2: With auto-sleep off, a start_req accepted at a clock edge makes adc_convst_n low right after that edge. It stays low for conv_lo_cycles cycles, with 0 treated as 1.
- R3: When busy has fallen, adc_cs_n and adc_rd_n go low together for rd_wait_cycles cycles, with 0 treated as 1. adc_data is latched at the edge that ends this window, and both strobes return high together after it. At that point res_valid is 1 for exactly one cycle, with the word on res_data.
- R4: Each res_data word is the converter's result for the most recent adc_convst_n falling edge. There is no added latency.
- R5: Two adc_convst_n falling edges are never closer than the grade minimum. Variant code 0 gives CLK_KHZ/400 cycles, code 1 gives CLK_KHZ/1000 cycles, and codes 2 and 3 give CLK_KHZ/1250 cycles. A start_req that comes earlier than this is ignored and sets overrun.
- R6: A start_req that arrives while a conversion is in WAKE, SAMPLE, CONVERT or READ is ignored and sets overrun. overrun stays 1 until reset.
- R7: With auto_en set, adc_convst_n falls every max(rate_period, grade minimum) cycles, provided the conversion finishes within that spacing.
- R8: With sleep_en set, wake_cycles cycles (0 treated as 1) pass between the accepting edge and the start of SAMPLE. The request-to-low latency is therefore 1 + wake_cycles.
- R9: adc_sleep_sel equals sleep_full, delayed by one register.
- R10: If no busy falling edge is seen within busy_limit cycles of CONVERT, timeout becomes 1 and stays 1 until reset. The machine returns to IDLE without a res_valid pulse.
- R11: adc_busy passes through a two-flop synchronizer before edge detection. Captures are correct for both the 34-cycle and the 44-cycle busy durations at 50 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Single-cycle conversion request |
| auto_en | input | 1 | Enable the internal rate timer |
| variant | input | 2 | Speed grade code (0 slow, 1 mid, 2/3 fast) |
| rate_period | input | CNT_W | Rate timer period in clocks |
| sleep_en | input | 1 | Auto-sleep policy, inserts wake delay |
| sleep_full | input | 1 | Full (1) or partial (0) sleep selection |
| wake_cycles | input | CNT_W | Wake delay before sampling |
| conv_lo_cycles | input | CNT_W | Convert-start low width |
| rd_wait_cycles | input | CNT_W | Read-strobe low cycles before latching |
| busy_limit | input | CNT_W | Watchdog limit in CONVERT |
| adc_busy | input | 1 | Converter busy, asynchronous |
| adc_data | input | DATA_W | Converter parallel result bus |
| adc_convst_n | output | 1 | Convert-start, falling edge samples |
| adc_cs_n | output | 1 | Chip-select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_sleep_sel | output | 1 | Sleep type select to the converter |
| res_valid | output | 1 | One-cycle result valid |
| res_data | output | DATA_W | Captured result word |
| overrun | output | 1 | Sticky dropped-request flag |
| timeout | output | 1 | Sticky busy watchdog flag |

## Verification
The main capture path is exercised with a table of configurations. Each entry varies convert-start width, read wait, busy duration, speed grade, and whether auto-sleep with a wake delay is on. The table also includes zero-valued widths, which expose any mishandling of the treat-as-one rule. The bench measures request latency and strobe widths at the pins, and compares every captured word with the bench's own count of sampling edges. That comparison separates a correct no-latency capture from an off-by-one result. Directed runs then cover the following:
- Rate-timer gaps for two speed grades and periods, which tell the configured period apart from the grade floor.
- Early and mid-conversion requests, which must drop the request and raise overrun.
- A busy that outlasts the watchdog.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_SAMPLE,
        ST_CONVERT,
        ST_READ
    } seq_state_t;

    // Minimum clocks between sampling edges for a speed grade (rounded up)
    function automatic int unsigned grade_gap(input int unsigned clk_khz,
                                              input int unsigned ksps);
        return (clk_khz + ksps - 1) / ksps;
    endfunction

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_in,
    output logic busy_q,
    output logic busy_fall
);
    logic meta_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            busy_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= busy_in;
            busy_q <= meta_q;
            prev_q <= busy_q;
        end
    end

    assign busy_fall = prev_q & ~busy_q;

endmodule

// File: rtl/adc_rate_gate.sv
module adc_rate_gate #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned CLK_KHZ = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark,
    input  logic [1:0]       variant,
    input  logic [CNT_W-1:0] rate_period,
    output logic             man_ok,
    output logic             auto_ok
);
    import adc_seq_pkg::*;

    localparam int unsigned GAP_SLOW_I = grade_gap(CLK_KHZ, 400);
    localparam int unsigned GAP_MID_I  = grade_gap(CLK_KHZ, 1000);
    localparam int unsigned GAP_FAST_I = grade_gap(CLK_KHZ, 1250);
    localparam logic [CNT_W-1:0] GAP_SLOW = CNT_W'(GAP_SLOW_I);
    localparam logic [CNT_W-1:0] GAP_MID  = CNT_W'(GAP_MID_I);
    localparam logic [CNT_W-1:0] GAP_FAST = CNT_W'(GAP_FAST_I);

    logic [CNT_W-1:0] since_q;
    logic [CNT_W-1:0] floor_gap;
    logic [CNT_W-1:0] auto_gap;

    always_ff @(posedge clk) begin
        if (!rst_n)
            since_q <= '1;
        else if (mark)
            since_q <= '0;
        else if (since_q != '1)
            since_q <= since_q + 1'b1;
    end

    always_comb begin
        unique case (variant)
            2'd0:    floor_gap = GAP_SLOW;
            2'd1:    floor_gap = GAP_MID;
            default: floor_gap = GAP_FAST;
        endcase
        auto_gap = (rate_period > floor_gap) ? rate_period : floor_gap;
        man_ok   = since_q >= (floor_gap - 1'b1);
        auto_ok  = since_q >= (auto_gap - 1'b1);
    end

    // R5
    gap_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark |-> man_ok);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int unsigned DATA_W  = 12,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned CLK_KHZ = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              auto_en,
    input  logic [1:0]        variant,
    input  logic [CNT_W-1:0]  rate_period,
    input  logic              sleep_en,
    input  logic              sleep_full,
    input  logic [CNT_W-1:0]  wake_cycles,
    input  logic [CNT_W-1:0]  conv_lo_cycles,
    input  logic [CNT_W-1:0]  rd_wait_cycles,
    input  logic [CNT_W-1:0]  busy_limit,
    input  logic              adc_busy,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_convst_n,
    output logic              adc_cs_n,
    output logic              adc_rd_n,
    output logic              adc_sleep_sel,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              overrun,
    output logic              timeout
);
    import adc_seq_pkg::*;

    seq_state_t       state_q, state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, busy_fall;
    logic             man_ok, auto_ok;
    logic             go, mark, wd_expire, read_end;

    function automatic logic [CNT_W-1:0] last_of(input logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    adc_busy_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_in   (adc_busy),
        .busy_q    (busy_q),
        .busy_fall (busy_fall)
    );

    adc_rate_gate #(.CNT_W(CNT_W), .CLK_KHZ(CLK_KHZ)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .mark        (mark),
        .variant     (variant),
        .rate_period (rate_period),
        .man_ok      (man_ok),
        .auto_ok     (auto_ok)
    );

    assign go        = (state_q == ST_IDLE) &&
                       ((start_req && man_ok) || (auto_en && auto_ok));
    assign wd_expire = (state_q == ST_CONVERT) && !busy_fall &&
                       (cnt_q == last_of(busy_limit));
    assign read_end  = (state_q == ST_READ) && (cnt_q == last_of(rd_wait_cycles));
    assign mark      = (state_nx == ST_SAMPLE) && (state_q != ST_SAMPLE);

    // Transition logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:    if (go) state_nx = sleep_en ? ST_WAKE : ST_SAMPLE;
            ST_WAKE:    if (cnt_q == last_of(wake_cycles)) state_nx = ST_SAMPLE;
            ST_SAMPLE:  if (cnt_q == last_of(conv_lo_cycles)) state_nx = ST_CONVERT;
            ST_CONVERT: begin
                if (busy_fall)      state_nx = ST_READ;
                else if (wd_expire) state_nx = ST_IDLE;
            end
            ST_READ:    if (read_end) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Per-state cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n || state_nx != state_q) cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
    end

    // Result capture and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid     <= 1'b0;
            res_data      <= '0;
            overrun       <= 1'b0;
            timeout       <= 1'b0;
            adc_sleep_sel <= 1'b0;
        end else begin
            res_valid     <= read_end;
            adc_sleep_sel <= sleep_full;
            if (read_end) res_data <= adc_data;
            if (start_req && !((state_q == ST_IDLE) && man_ok)) overrun <= 1'b1;
            if (wd_expire) timeout <= 1'b1;
        end
    end

    // Pin outputs
    always_comb begin
        adc_convst_n = (state_q != ST_SAMPLE);
        adc_cs_n     = (state_q != ST_READ);
        adc_rd_n     = (state_q != ST_READ);
    end

    // R3
    valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(!adc_rd_n));

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R6
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R10
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> timeout);

    // R11
    sample_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || timeout)
        $fell(adc_convst_n) |-> !busy_q);

endmodule

// File: tb/adc_stub.sv
module adc_stub #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         convst_n,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic [7:0]   busy_len,
    output logic         busy,
    output logic [W-1:0] data
);
    logic         prev_cv;
    logic [W-1:0] idx_q, held_q;
    logic [7:0]   left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_cv <= 1'b1;
            idx_q   <= '0;
            held_q  <= '0;
            left_q  <= '0;
            busy    <= 1'b0;
        end else begin
            prev_cv <= convst_n;
            if (prev_cv && !convst_n) begin
                held_q <= idx_q;
                idx_q  <= idx_q + 1'b1;
                left_q <= busy_len;
                busy   <= 1'b1;
            end else if (busy) begin
                if (left_q <= 8'd1) busy <= 1'b0;
                else                left_q <= left_q - 1'b1;
            end
        end
    end

    assign data = (!cs_n && !rd_n) ? held_q : '0;

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
    localparam int CNT_W = 16;
    localparam int DW    = 12;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic start_req = 0, auto_en = 0, sleep_en = 0, sleep_full = 0;
    logic [1:0] variant = 2'd1;
    logic [CNT_W-1:0] rate_period = 16'd10, wake_cycles = 16'd1;
    logic [CNT_W-1:0] conv_lo_cycles = 16'd2, rd_wait_cycles = 16'd2, busy_limit = 16'd200;
    logic [7:0] busy_len = 8'd44;
    logic adc_busy, adc_convst_n, adc_cs_n, adc_rd_n, adc_sleep_sel;
    logic res_valid, overrun, timeout;
    logic [DW-1:0] adc_data, res_data;

    adc_seq_ctrl #(.DATA_W(DW), .CNT_W(CNT_W), .CLK_KHZ(50000)) dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .auto_en(auto_en),
        .variant(variant), .rate_period(rate_period), .sleep_en(sleep_en),
        .sleep_full(sleep_full), .wake_cycles(wake_cycles),
        .conv_lo_cycles(conv_lo_cycles), .rd_wait_cycles(rd_wait_cycles),
        .busy_limit(busy_limit), .adc_busy(adc_busy), .adc_data(adc_data),
        .adc_convst_n(adc_convst_n), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
        .adc_sleep_sel(adc_sleep_sel), .res_valid(res_valid), .res_data(res_data),
        .overrun(overrun), .timeout(timeout)
    );

    adc_stub #(.W(DW)) u_stub (
        .clk(clk), .rst_n(rst_n), .convst_n(adc_convst_n), .cs_n(adc_cs_n),
        .rd_n(adc_rd_n), .busy_len(busy_len), .busy(adc_busy), .data(adc_data)
    );

    int n_run = 0, n_fail = 0, exp_idx = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_idx = 0;
    endtask

    task automatic pulse_req();
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    // Fields: sleep, wake, conv_lo, rd_wait, busy_len, variant
    localparam logic [47:0] VEC [5] = '{
        {8'd0, 8'd0, 8'd1, 8'd1, 8'd44, 8'd1},
        {8'd0, 8'd0, 8'd3, 8'd2, 8'd34, 8'd2},
        {8'd1, 8'd4, 8'd2, 8'd3, 8'd44, 8'd0},
        {8'd1, 8'd1, 8'd0, 8'd0, 8'd34, 8'd1},
        {8'd0, 8'd0, 8'd5, 8'd4, 8'd44, 8'd2}
    };

    task automatic one_conversion(input int exp_lat, input int exp_cw, input int exp_rw,
                                  input bit measure);
        int lat, cw, rw;
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        lat = 1;
        while (adc_convst_n) begin @(negedge clk); lat++; end
        cw = 0;
        while (!adc_convst_n) begin cw++; @(negedge clk); end
        while (adc_rd_n) @(negedge clk);
        rw = 0;
        while (!adc_rd_n) begin rw++; @(negedge clk); end
        if (measure) begin
            check(lat == exp_lat, "R2/R8 latency", lat, exp_lat);
            check(cw == exp_cw, "R2 convst width", cw, exp_cw);
            check(rw == exp_rw && adc_cs_n, "R3 read width", rw, exp_rw);
        end
        check(res_valid == 1'b1, "R3 valid pulse", res_valid, 1);
        check(res_data == DW'(exp_idx), "R4/R11 data", res_data, exp_idx);
        exp_idx++;
        @(negedge clk);
        check(res_valid == 1'b0, "R3 valid one cycle", res_valid, 0);
    endtask

    task automatic meas_gap(output int gap);
        bit prev;
        while (adc_convst_n) @(negedge clk);
        prev = 1'b0;
        gap = 0;
        forever begin
            @(negedge clk);
            gap++;
            if (prev && !adc_convst_n) break;
            prev = adc_convst_n;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int falls, gap, wlat;
        bit vseen;
        do_reset();
        @(negedge clk);
        // R1 reset state
        check(adc_convst_n && adc_cs_n && adc_rd_n && !res_valid && !overrun && !timeout,
              "R1 reset outputs", {adc_convst_n, adc_cs_n, adc_rd_n, res_valid, overrun, timeout},
              6'b111000);

        // Vector table walk
        foreach (VEC[i]) begin
            sleep_en       = VEC[i][47:40] != 0;
            wake_cycles    = CNT_W'(VEC[i][39:32]);
            conv_lo_cycles = CNT_W'(VEC[i][31:24]);
            rd_wait_cycles = CNT_W'(VEC[i][23:16]);
            busy_len       = VEC[i][15:8];
            variant        = VEC[i][1:0];
            wlat = sleep_en ? ((wake_cycles == 0) ? 2 : int'(wake_cycles) + 1) : 1;
            one_conversion(wlat,
                           (conv_lo_cycles == 0) ? 1 : int'(conv_lo_cycles),
                           (rd_wait_cycles == 0) ? 1 : int'(rd_wait_cycles), 1'b1);
            repeat (140) @(negedge clk);
        end
        sleep_en = 0;
        conv_lo_cycles = 2; rd_wait_cycles = 2;

        // R9 sleep select follows config
        sleep_full = 1'b1;
        repeat (2) @(negedge clk);
        check(adc_sleep_sel == 1'b1, "R9 sleep select high", adc_sleep_sel, 1);
        sleep_full = 1'b0;
        repeat (2) @(negedge clk);
        check(adc_sleep_sel == 1'b0, "R9 sleep select low", adc_sleep_sel, 0);

        // R6 request during conversion is dropped
        do_reset();
        variant = 2'd1; busy_len = 8'd44;
        @(negedge clk);
        pulse_req();
        repeat (5) @(negedge clk);
        pulse_req();
        check(overrun == 1'b1, "R6 overrun set", overrun, 1);
        while (!res_valid) @(negedge clk);
        check(res_data == DW'(exp_idx), "R4 data after drop", res_data, exp_idx);
        exp_idx++;
        falls = 0;
        for (int k = 0; k < 150; k++) begin
            @(negedge clk);
            if (!adc_convst_n) falls++;
        end
        check(falls == 0 && overrun, "R6 no extra conversion", falls, 0);

        // R5 too-early request on slow grade
        do_reset();
        variant = 2'd0; busy_len = 8'd34;
        one_conversion(1, 2, 2, 1'b0);
        check(overrun == 1'b0, "R5 no overrun yet", overrun, 0);
        pulse_req();
        falls = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!adc_convst_n) falls++;
        end
        check(falls == 0 && overrun, "R5 early request dropped", falls, 0);

        // R7 rate timer spacing
        do_reset();
        variant = 2'd1; busy_len = 8'd34; rate_period = 16'd10; auto_en = 1'b1;
        meas_gap(gap);
        meas_gap(gap);
        check(gap == 50, "R7/R5 auto gap at grade floor", gap, 50);
        variant = 2'd2; rate_period = 16'd90;
        meas_gap(gap);
        meas_gap(gap);
        check(gap == 90, "R7 auto gap at period", gap, 90);
        auto_en = 1'b0;
        repeat (150) @(negedge clk);

        // R10 watchdog
        do_reset();
        variant = 2'd1; busy_len = 8'd44; busy_limit = 16'd5;
        @(negedge clk);
        pulse_req();
        vseen = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (res_valid) vseen = 1;
        end
        check(timeout == 1'b1, "R10 timeout flag", timeout, 1);
        check(vseen == 1'b0, "R10 no valid on timeout", vseen, 0);
        busy_limit = 16'd200;
        do_reset();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule